// File: doc/BRIEF.md
# Recursive Odd-Output Post-Adder

This block is the final stage for the odd-indexed outputs of a serial DCT pipeline. It takes a stream of intermediate values F(k), one word per transfer, and turns each into an odd DCT output. The first element of a sequence is halved. Every later element has the previous output subtracted from it. A single accumulator holds the previous output. One subtractor is always in the datapath. A one-bit arithmetic shift stands in for the 0.5 factor.

Data flows through valid/ready handshakes. The output is combinational from the input, so each result appears in the same cycle as its input. Back-pressure passes straight through: the input is ready exactly when the output is ready. A transfer happens on a clock edge where `in_valid` and `out_ready` are both high. State changes only on a transfer. The `in_start` flag travels with the data word and marks the first element of a sequence. Inputs must arrive in natural index order.

Top module: `odd_post_adder`

## Requirements
- R1: The first element of a sequence produces floor(F/2), an arithmetic right shift by one that rounds toward negative infinity. For example, F = -3 gives -2.
- R2: Every later element of a sequence produces F minus the output of the previous transfer.
- R3: A transfer with `in_start` high begins a new sequence at any position, including in the middle of a sequence. The accumulator is treated as cleared for that element.
- R4: After LEN transfers without a new `in_start`, the next transfer is treated as a first element even if `in_start` is low. The first transfer after reset is also treated as a first element.
- R5: There is no pipeline latency. `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `out_data` holds the result of the current input in the same cycle.
- R6: Without a transfer, neither the accumulator nor the sequence position changes. A stalled word, its `in_start`, and any idle cycles leave the next result unaffected.
- R7: `out_data` is DW+clog2(LEN) bits in two's complement. This width is wide enough that no sequence of DW-bit inputs overflows it. With DW=8 and LEN=4, the inputs -128, 127, -128, 127 give -64, 191, -319, 446.
- R8: During reset the accumulator clears and the sequence position is set so that the next transfer starts a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input accepted when high (equals out_ready) |
| in_data | input | DW | Signed intermediate value F(k) |
| in_start | input | 1 | Marks first element of a sequence |
| out_valid | output | 1 | Result valid (equals in_valid) |
| out_ready | input | 1 | Downstream can take the result |
| out_data | output | DW+clog2(LEN) | Signed odd DCT output |

## Verification
Every result is due in the same cycle as its input, before the edge that accepts it. The bench therefore drives each word just after a falling edge and checks the output one time unit later, before the next rising edge. The effect of the accumulator appears only in the result of the next accepted word. Stall and idle checks therefore look at the word that follows the stalled or idle cycles.

// File: rtl/odd_post_pkg.sv
package odd_post_pkg;
  function automatic int out_width(int dw, int len);
    return dw + $clog2(len);
  endfunction
endpackage

// File: rtl/odd_post_seqpos.sv
module odd_post_seqpos #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic start,
  output logic first
);
  localparam int PW = $clog2(LEN + 1);

  logic [PW-1:0] pos;

  assign first = start || (pos == PW'(LEN));

  always_ff @(posedge clk) begin
    if (!rst_n)    pos <= PW'(LEN);
    else if (fire) pos <= first ? PW'(1) : pos + PW'(1);
  end

  // R4: position never runs past the sequence length
  p_pos_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= PW'(LEN));
  // R6: position moves only on a transfer
  p_pos_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(pos));
endmodule

// File: rtl/odd_post_datapath.sv
module odd_post_datapath #(
  parameter int DW = 8,
  parameter int OW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          first,
  input  logic [DW-1:0] in_data,
  output logic [OW-1:0] result
);
  logic signed [OW-1:0] acc, ext, scaled, prior, diff;

  assign ext    = {{(OW-DW){in_data[DW-1]}}, in_data};
  assign scaled = first ? (ext >>> 1) : ext;
  assign prior  = first ? '0 : acc;
  assign diff   = scaled - prior;
  assign result = diff;

  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= '0;
    else if (fire) acc <= diff;
  end

  // R6: accumulator holds when no word is taken
  p_acc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(acc));
  // R2: accumulator keeps the last delivered output
  p_acc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> acc == $past(result));
endmodule

// File: rtl/odd_post_adder.sv
module odd_post_adder #(
  parameter int DW  = 8,
  parameter int LEN = 4,
  parameter int OW  = odd_post_pkg::out_width(DW, LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_start,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_data
);
  logic fire, first;

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign fire      = in_valid && out_ready;

  odd_post_seqpos #(.LEN(LEN)) u_pos (
    .clk(clk), .rst_n(rst_n), .fire(fire), .start(in_start), .first(first)
  );

  odd_post_datapath #(.DW(DW), .OW(OW)) u_dp (
    .clk(clk), .rst_n(rst_n), .fire(fire), .first(first),
    .in_data(in_data), .result(out_data)
  );

  // R3: a started word yields the halved input at the port
  p_start_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_start) |-> ($signed(out_data) ==
      ($signed({{(OW-DW){in_data[DW-1]}}, in_data}) >>> 1)));
endmodule

// File: tb/test_odd_post_adder.sv
module test_odd_post_adder;
  localparam int DW = 8, LEN = 4, OW = DW + 2;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_start = 0, out_ready = 1;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [OW-1:0] out_data;
  int n_run = 0, n_fail = 0;
  int m_prev = 0, m_pos = LEN;

  always #4 clk = ~clk;

  odd_post_adder #(.DW(DW), .LEN(LEN)) i_odd_post_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_start(in_start), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  function automatic int floor_half(int f);
    if (f < 0 && (f % 2) != 0) return (f - 1) / 2;
    return f / 2;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle; check results before the edge; update the model.
  task automatic step(input bit v, input bit s, input int f, input bit rdy,
                      input string req);
    int exp;
    bit first;
    @(negedge clk);
    in_valid = v; in_start = s; in_data = DW'(f); out_ready = rdy;
    #1;
    chk({req, "/R5 valid"}, int'(out_valid), int'(v));
    chk({req, "/R5 ready"}, int'(in_ready), int'(rdy));
    first = s || (m_pos == LEN);
    exp = first ? floor_half(f) : f - m_prev;
    if (v) chk(req, $signed(out_data), exp);
    if (v && rdy) begin
      m_prev = exp;
      m_pos  = first ? 1 : m_pos + 1;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_start = 0; out_ready = 1;
  endtask

  task automatic t_reset();
    #1;
    chk("R8 out_valid in reset", int'(out_valid), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // first word after reset with no start is still a first element
    step(1, 0, 10, 1, "R4 post-reset first");
    step(1, 0, 7, 1, "R2 chain");
    step(1, 1, 0, 1, "R3 resync");
    step(1, 0, 0, 1, "R2 chain");
    step(1, 0, 0, 1, "R2 chain");
    step(1, 0, 0, 1, "R2 chain");
  endtask

  task automatic t_seq4();
    step(1, 1, 20, 1, "R1 first");
    step(1, 0, 30, 1, "R2 k1");
    step(1, 0, -5, 1, "R2 k2");
    step(1, 0, 12, 1, "R2 k3");
  endtask

  task automatic t_round();
    step(1, 1, -3, 1, "R1 round -3");
    step(1, 0, 1, 1, "R2 after neg");
    step(1, 0, 2, 1, "R2");
    step(1, 0, 3, 1, "R2");
    step(1, 1, 3, 1, "R1 round 3");
    step(1, 0, 0, 1, "R2");
    step(1, 0, 0, 1, "R2");
    step(1, 0, 0, 1, "R2");
  endtask

  task automatic t_early();
    step(1, 1, 40, 1, "R1 first");
    step(1, 0, 9, 1, "R2 k1");
    step(1, 1, 17, 1, "R3 early start");
    step(1, 0, 4, 1, "R3 chain after early start");
  endtask

  task automatic t_wrap();
    step(1, 1, 8, 1, "R1");
    step(1, 0, 1, 1, "R2");
    step(1, 0, 2, 1, "R2");
    step(1, 0, 3, 1, "R2");
    step(1, 0, -9, 1, "R4 missing start wraps");
    step(1, 0, 6, 1, "R4 chain after wrap");
    step(1, 0, 0, 1, "R2");
    step(1, 0, 0, 1, "R2");
  endtask

  task automatic t_stall();
    step(1, 1, 50, 1, "R1");
    step(1, 1, 99, 0, "R6 stalled word");
    step(1, 0, 77, 0, "R6 stalled word");
    idle(); idle();
    step(1, 0, 11, 1, "R6 after stall and idle");
    chk("R6 chain value", m_prev, 11 - 25);
    step(1, 0, 0, 1, "R2");
    step(1, 0, 0, 1, "R2");
  endtask

  task automatic t_extreme();
    step(1, 1, -128, 1, "R7 x0");
    chk("R7 x0 value", m_prev, -64);
    step(1, 0, 127, 1, "R7 x1");
    step(1, 0, -128, 1, "R7 x2");
    step(1, 0, 127, 1, "R7 x3");
    chk("R7 x3 value", m_prev, 446);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_seq4(); t_round(); t_early(); t_wrap();
        t_stall(); t_extreme(); idle();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule